// File: doc/BRIEF.md
# Per-Event Pending Occurrence Counter

This block keeps track of how many occurrences of a single event source are still waiting to be served, without storing any payload. Each event pulse adds one to a small saturating occupancy count, and each acknowledge from the downstream arbiter removes one. While at least one occurrence is outstanding, the block raises a pending output that the arbiter uses as its request for this source.

The count is bounded by a depth parameter (four by default). An event that arrives when the count already sits at that bound cannot be recorded. In that case the count is left at the bound and a one-cycle error pulse is raised, so that a logging stage elsewhere can note the lost occurrence. An event and an acknowledge in the same cycle cancel each other. An acknowledge that arrives with nothing outstanding is discarded.

Top module: `evt_pend_queue`

## Requirements
- R1: A low level on `rst_ni` clears the count at once, without waiting for a clock edge. `pend_o` and `err_o` are 0 while reset is held and after it is released.
- R2: At a rising clock edge with `evt_i`=1, `ack_i`=0 and the count below DEPTH, the count goes up by one.
- R3: At a rising clock edge with `ack_i`=1, `evt_i`=0 and a non-zero count, the count goes down by one.
- R4: `pend_o` is 1 exactly when the count is non-zero. It follows the count in the same cycle.
- R5: The count holds up to DEPTH (4) occurrences. After DEPTH events, exactly DEPTH acknowledges are needed before `pend_o` falls.
- R6: An edge with both `evt_i`=1 and `ack_i`=1 leaves the count unchanged. This also holds when the count is at DEPTH, and no error is raised in that case.
- R7: An edge with `evt_i`=1 and `ack_i`=0 while the count is at DEPTH keeps the count at DEPTH. It sets `err_o` to 1 for the following cycle only; repeated overflowing edges give one such cycle each.
- R8: An acknowledge alone while the count is zero is ignored. The count stays at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | One-cycle pulse marking a new occurrence |
| ack_i | input | 1 | The arbiter has served one occurrence |
| pend_o | output | 1 | At least one occurrence is outstanding |
| err_o | output | 1 | Registered pulse: an occurrence was lost at full |

## Verification
The hardest states to reach are the two at full occupancy: an overflowing event, and an event that coincides with an acknowledge. Both need four unacknowledged events first, and the count itself is never visible at the ports. The stimulus table fills the counter with four plain events and then applies both full-occupancy cases. It then drains the counter with single acknowledges and counts how many are needed before the pending output drops. That count shows the value was held at four and not pushed beyond it. A directed reset asserted between clock edges, followed by one acknowledge, shows that the count was cleared at once.

// File: rtl/evt_pend_pkg.sv
// Package: shared types for the per-event pending counter.
// Assumes: nothing; type definitions only.
package evt_pend_pkg;

    // Action the counter takes at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,   // no change
        OP_INC  = 2'd1,   // record one more occurrence
        OP_DEC  = 2'd2,   // one occurrence served
        OP_OVF  = 2'd3    // occurrence lost, queue already full
    } pend_op_e;

endpackage

// File: rtl/evt_pend_decode.sv
// Module: evt_pend_decode
// Turns the event/acknowledge pair and the occupancy state into the single
// action the counter performs at the next edge.
// Assumes: full_i and empty_i are never both high (DEPTH >= 1).
module evt_pend_decode
    import evt_pend_pkg::*;
(
    input  logic     evt_i,
    input  logic     ack_i,
    input  logic     full_i,
    input  logic     empty_i,
    output pend_op_e op_o
);

    // Purpose: select the action; a coincident event and acknowledge cancel out.
    always_comb begin
        op_o = OP_HOLD;
        if (evt_i && !ack_i) begin
            op_o = full_i ? OP_OVF : OP_INC;
        end else if (ack_i && !evt_i && !empty_i) begin
            op_o = OP_DEC;
        end
    end

endmodule

// File: rtl/evt_pend_counter.sv
// Module: evt_pend_counter
// Saturating occupancy counter from 0 to DEPTH, driven by a decoded action.
// Assumes: the decoder never requests OP_INC at full or OP_DEC at empty.
module evt_pend_counter
    import evt_pend_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  pend_op_e      op_i,
    output logic [CW-1:0] cnt_o,
    output logic          full_o,
    output logic          empty_o
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    // Purpose: hold the occupancy; asynchronous clear on reset.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            case (op_i)
                OP_INC:  cnt_q <= cnt_q + ONE;
                OP_DEC:  cnt_q <= cnt_q - ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign full_o  = (cnt_q == FULL_LVL);
    assign empty_o = (cnt_q == '0);

    // R5: occupancy never exceeds the configured depth
    p_depth_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_OVF) |=> (cnt_q == FULL_LVL));

endmodule

// File: rtl/evt_pend_queue.sv
// Module: evt_pend_queue (top)
// Counts outstanding occurrences of one event source, flags pending work and
// pulses an error when an occurrence arrives at full occupancy.
// Assumes: evt_i is a one-cycle pulse per occurrence; ack_i is high only when
// this source was granted and all destinations were ready.
module evt_pend_queue
    import evt_pend_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic ack_i,
    output logic pend_o,
    output logic err_o
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE      = CW'(1);

    pend_op_e      op;
    logic [CW-1:0] cnt;
    logic          full;
    logic          empty;
    logic          err_q;

    evt_pend_decode u_decode (
        .evt_i   (evt_i),
        .ack_i   (ack_i),
        .full_i  (full),
        .empty_i (empty),
        .op_o    (op)
    );

    evt_pend_counter #(.DEPTH(DEPTH)) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .op_i    (op),
        .cnt_o   (cnt),
        .full_o  (full),
        .empty_o (empty)
    );

    // Purpose: register the overflow indication as a one-cycle error pulse.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (op == OP_OVF);
        end
    end

    assign pend_o = !empty;
    assign err_o  = err_q;

    // R2: a lone event below full adds one
    p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && !ack_i && cnt != FULL_LVL) |=> (cnt == $past(cnt) + ONE));

    // R3: a lone acknowledge with work outstanding removes one
    p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !evt_i && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    // R6: coincident event and acknowledge change nothing and raise no error
    p_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && ack_i) |=> ($stable(cnt) && !err_o));

    // R7: an event at full holds the count and raises the error
    p_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && !ack_i && cnt == FULL_LVL) |=> (err_o && cnt == FULL_LVL));

    // R7: no error without an overflowing event on the previous edge
    p_no_spurious_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(evt_i && !ack_i && cnt == FULL_LVL) |=> !err_o);

    // R8: an acknowledge with nothing outstanding is discarded
    p_idle_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !evt_i && cnt == '0) |=> (cnt == '0 && !pend_o));

endmodule

// File: tb/evt_pend_queue_tb_top.sv
module evt_pend_queue_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 1'b0;
    logic ack = 1'b0;
    logic pend;
    logic err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    evt_pend_queue #(.DEPTH(4)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .evt_i  (evt),
        .ack_i  (ack),
        .pend_o (pend),
        .err_o  (err)
    );

    // Each entry: {evt, ack, expected pend, expected err} after one edge.
    localparam int NVEC = 16;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0100,  // R8 ack at zero, count 0
        4'b1010,  // R2 count 1
        4'b1110,  // R6 cancel, count 1
        4'b0100,  // R3 count 0, R4 pend low
        4'b1010,  // R2 count 1
        4'b1010,  // R2 count 2
        4'b1010,  // R2 count 3
        4'b1010,  // R5 count 4
        4'b1011,  // R7 overflow, count 4, err
        4'b0010,  // R7 err lasts one cycle
        4'b1110,  // R6 cancel at full, no err
        4'b0110,  // R5 count 3
        4'b0110,  // R5 count 2
        4'b0110,  // R5 count 1
        4'b0100,  // R5 fourth ack empties, R4 pend low
        4'b0100   // R8 ack at zero again
    };
    localparam int VREQ [NVEC] = '{8, 2, 6, 3, 2, 2, 2, 5, 7, 7, 6, 5, 5, 5, 5, 8};

    task automatic check(input int req, input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive at falling edge, sample shortly after the following rising edge.
    task automatic step(input logic e, input logic a);
        @(negedge clk);
        evt = e;
        ack = a;
        @(posedge clk);
        #2;
        evt = 1'b0;
        ack = 1'b0;
    endtask

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        #2;
        check(1, pend, 1'b0, "pend in reset");
        check(1, err, 1'b0, "err in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(1, pend, 1'b0, "pend after reset");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3], VEC[i][2]);
            check(VREQ[i], pend, VEC[i][1], $sformatf("vec %0d pend", i));
            check(VREQ[i], err, VEC[i][0], $sformatf("vec %0d err", i));
        end

        // R7 back-to-back overflows each give an error cycle
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(7, err, 1'b1, "first overflow");
        step(1'b1, 1'b0);
        check(7, err, 1'b1, "second overflow");
        step(1'b0, 1'b0);
        check(7, err, 1'b0, "idle after overflows");
        check(5, pend, 1'b1, "still full");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        check(5, pend, 1'b1, "one left after three acks");
        step(1'b0, 1'b1);
        check(5, pend, 1'b0, "empty after four acks");

        // R1 asynchronous clear between edges
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(2, pend, 1'b1, "two outstanding");
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check(1, pend, 1'b0, "pend cleared without edge");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0);
        check(1, pend, 1'b1, "one after reset");
        step(1'b0, 1'b1);
        check(1, pend, 1'b0, "single ack drains: count was zero");
        check(1, err, 1'b0, "err after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule